// File: doc/BRIEF.md
# Preemption Verify Handshake Controller

This block runs the verification handshake that one Ethernet port uses before it turns on frame preemption. Software brings up the port with the hold input high. That input holds the controller in its idle state. When software drops hold, the controller starts a new verification sequence. It raises a request to the transmit path to send one verify packet. Once the transmit path accepts the request, a response window opens. The window length is a count of cycles of the port's wireside clock. That clock runs at 125 MHz at gigabit speed and on serial gigabit links, 25 MHz at 100 Mb/s and 2.5 MHz at 10 Mb/s, so software scales the count with the link speed. A count of 1,250,000 (0x1312D0) gives 10 ms at 125 MHz.

If the receive path reports a respond packet while the window is open, verification succeeds. If a window closes with no response, the controller sends another request, up to three requests in all. When the third window closes with no response, it reports failure. When verification is disabled, the controller declares success at once and sends nothing. Success and failure both hold until software raises hold again.

Top module: `merge_verify_ctrl`

## Requirements
- R1: While hold_i is high at a clock edge, the controller returns to idle on that edge. In idle, req_o, busy_o, ok_o and fail_o are all 0. The next release starts afresh with a full budget of three requests.
- R2: On the first edge where hold_i is low and verify_en_i is high, the controller leaves idle. From that edge on, req_o and busy_o are 1.
- R3: req_o stays at 1 until an edge that samples req_ack_i high. It is 0 after that edge. A respond indication that arrives while the request is still pending is ignored.
- R4: The edge that accepts a request opens a response window. The window lasts timeout_i+1 cycles, and timeout_i is sampled on that accepting edge. If resp_seen_i is high at any edge inside the window, including the last one, ok_o is 1 from that edge on, and no further request is sent.
- R5: A window can close with no response after the first or second request. In that case req_o rises again on the edge that closes the window.
- R6: When the window after the third request closes with no response, fail_o is 1 and busy_o is 0 from that edge on.
- R7: On release with verify_en_i low, ok_o is 1 from the first edge and req_o never rises.
- R8: ok_o and fail_o stay set until hold_i is raised. resp_seen_i, req_ack_i, timeout_i and verify_en_i have no effect on them in the meantime.
- R9: At most one of busy_o, ok_o and fail_o is 1 at any time.
- R10: Each request loads its own window length from timeout_i. A change to timeout_i while a window is open does not alter that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Wireside clock of the port |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_i | input | 1 | Link-fail control: 1 holds idle, a transition to 0 starts verification |
| verify_en_i | input | 1 | 1 runs the handshake, 0 reports success directly |
| timeout_i | input | TCNT_W (24) | Response window length in wireside clock cycles |
| req_o | output | 1 | Verify packet request to the transmit path |
| req_ack_i | input | 1 | Transmit path accepts the pending request |
| resp_seen_i | input | 1 | Receive path saw a respond packet |
| busy_o | output | 1 | Verification in progress |
| ok_o | output | 1 | Verification succeeded (sticky) |
| fail_o | output | 1 | All attempts timed out (sticky) |

## Verification
Every result appears on the edge that samples its cause, with exactly one register stage. req_o rises on the edge after release. It falls on the accepting edge. ok_o follows the sampled response, and a new request or fail_o appears on the edge that ends a window of timeout_i+1 cycles. The bench drives inputs and samples outputs one nanosecond after each rising edge, then counts edges from the accepting edge. It checks the last cycle inside each window and the first cycle after it, so an error of one cycle in the window length shows up as a miscompare.

// File: rtl/mvc_pkg.sv
`timescale 1ns/1ps
package mvc_pkg;
  typedef enum logic [2:0] {
    MV_IDLE = 3'd0,
    MV_SEND = 3'd1,
    MV_WAIT = 3'd2,
    MV_OK   = 3'd3,
    MV_FAIL = 3'd4
  } mv_state_e;
endpackage

// File: rtl/mvc_rst_sync.sv
`timescale 1ns/1ps
module mvc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/mvc_timer.sv
`timescale 1ns/1ps
// Response window down-counter, loaded once per request.
module mvc_timer #(
  parameter int TCNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              dec_i,
  input  logic [TCNT_W-1:0] init_i,
  output logic              zero_o
);
  logic [TCNT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = init_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mvc_tries.sv
`timescale 1ns/1ps
// Counts verify requests accepted since the last idle state.
module mvc_tries #(
  parameter int MAX_TRIES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] TRY_LIM = TRY_W'(MAX_TRIES);

  logic [TRY_W-1:0] n_q, n_d;
  logic             n_en;

  always_comb begin
    n_en = 1'b0;
    n_d  = n_q;
    if (clr_i) begin
      n_en = 1'b1;
      n_d  = '0;
    end else if (inc_i && (n_q != TRY_LIM)) begin
      n_en = 1'b1;
      n_d  = n_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   n_q <= '0;
    else if (n_en) n_q <= n_d;
  end

  assign last_o = (n_q == TRY_LIM);
endmodule

// File: rtl/mvc_fsm.sv
`timescale 1ns/1ps
module mvc_fsm
  import mvc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  logic      verify_en_i,
  input  logic      ack_i,
  input  logic      resp_i,
  input  logic      win_zero_i,
  input  logic      last_try_i,
  output logic      load_o,
  output logic      dec_o,
  output logic      clr_o,
  output mv_state_e state_o
);
  mv_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MV_IDLE: st_d = verify_en_i ? MV_SEND : MV_OK;
      MV_SEND: if (ack_i) st_d = MV_WAIT;
      MV_WAIT: begin
        if (resp_i)          st_d = MV_OK;
        else if (win_zero_i) st_d = last_try_i ? MV_FAIL : MV_SEND;
      end
      MV_OK:   st_d = MV_OK;
      MV_FAIL: st_d = MV_FAIL;
      default: st_d = MV_IDLE;
    endcase
    if (hold_i) st_d = MV_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= MV_IDLE;
    else         st_q <= st_d;
  end

  assign load_o  = (st_q == MV_SEND) && ack_i && !hold_i;
  assign dec_o   = (st_q == MV_WAIT);
  assign clr_o   = (st_q == MV_IDLE);
  assign state_o = st_q;
endmodule

// File: rtl/merge_verify_ctrl.sv
`timescale 1ns/1ps
module merge_verify_ctrl
  import mvc_pkg::*;
#(
  parameter int TCNT_W    = 24,
  parameter int MAX_TRIES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              verify_en_i,
  input  logic [TCNT_W-1:0] timeout_i,
  output logic              req_o,
  input  logic              req_ack_i,
  input  logic              resp_seen_i,
  output logic              busy_o,
  output logic              ok_o,
  output logic              fail_o
);
  logic      rst_core_n;
  logic      load, dec, clr, win_zero, last_try;
  mv_state_e state;

  mvc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_core_n)
  );

  mvc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_core_n),
    .hold_i     (hold_i),
    .verify_en_i(verify_en_i),
    .ack_i      (req_ack_i),
    .resp_i     (resp_seen_i),
    .win_zero_i (win_zero),
    .last_try_i (last_try),
    .load_o     (load),
    .dec_o      (dec),
    .clr_o      (clr),
    .state_o    (state)
  );

  mvc_timer #(.TCNT_W(TCNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_core_n),
    .load_i(load),
    .dec_i (dec),
    .init_i(timeout_i),
    .zero_o(win_zero)
  );

  mvc_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk_i (clk_i),
    .rst_ni(rst_core_n),
    .clr_i (clr),
    .inc_i (load),
    .last_o(last_try)
  );

  assign req_o  = (state == MV_SEND);
  assign busy_o = (state == MV_SEND) || (state == MV_WAIT);
  assign ok_o   = (state == MV_OK);
  assign fail_o = (state == MV_FAIL);
endmodule

// File: rtl/mvc_checker.sv
`timescale 1ns/1ps
module mvc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_i,
  input logic verify_en_i,
  input logic req_o,
  input logic req_ack_i,
  input logic busy_o,
  input logic ok_o,
  input logic fail_o
);
  logic idle;
  assign idle = !busy_o && !ok_o && !fail_o;

  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (idle && !req_o));

  assert_req_inside_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_ack_i && !hold_i) |=> req_o);

  assert_ok_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && !hold_i) |=> ok_o);

  assert_fail_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !hold_i) |=> fail_o);

  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !hold_i && !verify_en_i) |=> (ok_o && !req_o));

  assert_status_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, ok_o, fail_o}));
endmodule

bind merge_verify_ctrl mvc_checker u_mvc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_core_n),
  .hold_i     (hold_i),
  .verify_en_i(verify_en_i),
  .req_o      (req_o),
  .req_ack_i  (req_ack_i),
  .busy_o     (busy_o),
  .ok_o       (ok_o),
  .fail_o     (fail_o)
);

// File: tb/merge_verify_ctrl_bench.sv
`timescale 1ns/1ps
module merge_verify_ctrl_bench;
  localparam int TW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hold, ven, ack, resp;
  logic [TW-1:0] tmo;
  logic          req, busy, ok, fail;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 1'b0;

  always #2 clk = ~clk;

  merge_verify_ctrl #(.TCNT_W(TW), .MAX_TRIES(3)) u_merge_verify_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .verify_en_i(ven),
    .timeout_i(tmo), .req_o(req), .req_ack_i(ack), .resp_seen_i(resp),
    .busy_o(busy), .ok_o(ok), .fail_o(fail)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // order of bits: req, busy, ok, fail
  task automatic expect_out(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {req, busy, ok, fail};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {req,busy,ok,fail} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic release_hold(logic en);
    hold = 1'b1; ven = en; ack = 1'b0; resp = 1'b0;
    step();
    hold = 1'b0;
    step();
  endtask

  task automatic accept();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hold = 1'b1; ven = 1'b1; ack = 1'b0; resp = 1'b0; tmo = '0;
    step(3);
    expect_out("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    step(4);
    expect_out("R1 held after reset", 4'b0000);
  endtask

  task automatic t_first_try_ok();
    tmo = 24'd6;
    release_hold(1'b1);
    expect_out("R2 request after release", 4'b1100);
    accept();
    expect_out("R3 request drops on accept", 4'b0100);
    step(2);
    resp = 1'b1;
    step();
    resp = 1'b0;
    expect_out("R4 success on response", 4'b0010);
    step(10);
    expect_out("R4 no further request", 4'b0010);
  endtask

  task automatic t_retry_then_ok();
    tmo = 24'd4;
    release_hold(1'b1);
    accept();
    step(4);
    expect_out("R4 window still open at T", 4'b0100);
    step();
    expect_out("R5 second request at T+1", 4'b1100);
    accept();
    step(4);
    resp = 1'b1;
    step();
    resp = 1'b0;
    expect_out("R4 response on last window cycle", 4'b0010);
  endtask

  task automatic t_three_timeouts(string tag);
    tmo = 24'd2;
    for (int i = 1; i <= 3; i++) begin
      expect_out({tag, " R5 request pending"}, 4'b1100);
      accept();
      step(2);
      expect_out({tag, " R4 window open"}, 4'b0100);
      step();
      if (i < 3) expect_out({tag, " R5 retry issued"}, 4'b1100);
      else       expect_out({tag, " R6 failure after third"}, 4'b0001);
    end
  endtask

  task automatic t_fail();
    release_hold(1'b1);
    t_three_timeouts("fail");
    resp = 1'b1; ack = 1'b1; ven = 1'b0; tmo = 24'd1;
    step(3);
    resp = 1'b0; ack = 1'b0;
    expect_out("R8 failure sticky", 4'b0001);
    hold = 1'b1;
    step();
    expect_out("R1 hold clears failure", 4'b0000);
  endtask

  task automatic t_bypass();
    ven = 1'b0;
    release_hold(1'b0);
    expect_out("R7 bypass success", 4'b0010);
    resp = 1'b1; ven = 1'b1;
    step(5);
    resp = 1'b0;
    expect_out("R8 success sticky", 4'b0010);
    hold = 1'b1;
    step();
    expect_out("R1 hold clears success", 4'b0000);
  endtask

  task automatic t_pending_req();
    release_hold(1'b1);
    step(5);
    expect_out("R3 request held without accept", 4'b1100);
    resp = 1'b1;
    step();
    resp = 1'b0;
    expect_out("R3 response ignored while pending", 4'b1100);
  endtask

  task automatic t_hold_mid();
    tmo = 24'd3;
    release_hold(1'b1);
    accept();
    accept();
    step();
    hold = 1'b1;
    step();
    expect_out("R1 hold aborts window", 4'b0000);
    hold = 1'b0;
    step();
    t_three_timeouts("restart R1");
  endtask

  task automatic t_reload();
    tmo = 24'd1;
    release_hold(1'b1);
    accept();
    tmo = 24'd5;
    step(1);
    expect_out("R10 window unaffected by change", 4'b0100);
    step();
    expect_out("R10 first window length kept", 4'b1100);
    accept();
    step(5);
    expect_out("R10 second window uses new count", 4'b0100);
    step();
    expect_out("R10 second window ends", 4'b1100);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_try_ok();
    t_retry_then_ok();
    t_fail();
    t_bypass();
    t_pending_req();
    t_hold_mid();
    t_reload();
    done = 1'b1;
    report();
    $finish;
  end
endmodule